// File: doc/BRIEF.md
# Serial 0-1-0 Recognizer with Permanent 1-0-0 Lockout

This block watches a single serial bit stream, one bit per clock, and raises a flag for one clock period each time the three most recent bits were 0, then 1, then 0. Matches may overlap, so the final 0 of one match can be the first 0 of the next.

A second pattern, 1 then 0 then 0, acts as a kill condition. Once that pattern has occurred anywhere in the stream since the last reset, the recognizer drops into a trap state. In that state the flag stays low whatever arrives, and only a reset releases it.

The recognizer is a Moore machine with seven states. The flag is decoded from the state register alone, so it changes only at clock edges. A typical use is as a small control watcher beside a datapath, with the synchronous reset re-arming it.

Top module: `sk_pattern_recognizer`

## Requirements
- R1: A rising clock edge with `rst_n` low puts the machine in its initial state, so `z` is 0 after that edge. Recognition after reset starts from an empty history.
- R2: `z` is 1 during the clock period that follows the edge sampling the third bit of 0,1,0 on consecutive edges, provided that no 1,0,0 has been sampled since reset. Otherwise `z` is 0.
- R3: Overlapping matches are recognised. For example, the input 0,1,0,1,0 raises `z` after the third bit and again after the fifth.
- R4: After 1,0,0 has been sampled on consecutive edges since reset, `z` stays 0 on every later cycle for any input, until a reset edge.
- R5: A 0 that follows a completed 0,1,0 completes 1,0,0 and kills detection. Neither a later 1,0 nor any longer sequence raises `z` again before reset.
- R6: Reset takes priority over `x`, and a reset edge also leaves the locked state. After release, a fresh 0,1,0 raises `z` again.
- R7: `z` is a registered output. It does not change between clock edges, even when `x` toggles mid-cycle.
- R8: Any run of leading 0s, or a run of 1s followed by 0, then 1, then 0 (for example 1,1,0,1,0), still produces a match on the final 0. This holds as long as no 1,0,0 has appeared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Serial data bit, sampled on each rising edge |
| z | output | 1 | Match flag, 1 for one period after 0,1,0 when not locked |

## Verification
The assertions assume that `x` and `rst_n` are stable, known values at every rising edge. They also assume that each history-based check refers only to edges taken with reset released; the properties gate themselves on the past values of `rst_n` to enforce this. The bench drives `x` and `rst_n` only on falling edges, and toggles `x` mid-high-phase only to probe that `z` stays unchanged. A behavioural model keeps a queue of the bits sampled since reset plus a kill flag, and it predicts `z` after every edge.

// File: rtl/sk_pkg.sv
// Package: shared state type for the serial recognizer.
// Assumes: seven states in total, so a 3-bit binary encoding is enough.
package sk_pkg;

    localparam int STATE_W = 3;

    // Each state names the longest useful suffix of the history seen so far.
    typedef enum logic [STATE_W-1:0] {
        ST_START  = 3'd0,  // nothing useful seen since reset
        ST_TAIL0  = 3'd1,  // history ends in 0, no 1 seen yet
        ST_TAIL01 = 3'd2,  // history ends in 0,1
        ST_HIT    = 3'd3,  // history ends in 0,1,0 (flag high)
        ST_TAIL1  = 3'd4,  // history ends in 1
        ST_TAIL10 = 3'd5,  // history ends in 1,0
        ST_LOCKED = 3'd6   // 1,0,0 seen: trap until reset
    } sk_state_e;

endpackage

// File: rtl/sk_next_state.sv
// Module: next-state function of the recognizer.
// Assumes: pure combinational logic; the caller applies reset.
module sk_next_state
    import sk_pkg::*;
(
    input  sk_state_e cur_state,
    input  logic      bit_in,
    output sk_state_e nxt_state
);

    // Purpose: pick the successor state from the present state and input bit.
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_START:  nxt_state = bit_in ? ST_TAIL1  : ST_TAIL0;
            ST_TAIL0:  nxt_state = bit_in ? ST_TAIL01 : ST_TAIL0;
            ST_TAIL01: nxt_state = bit_in ? ST_TAIL1  : ST_HIT;
            ST_HIT:    nxt_state = bit_in ? ST_TAIL01 : ST_LOCKED;
            ST_TAIL1:  nxt_state = bit_in ? ST_TAIL1  : ST_TAIL10;
            ST_TAIL10: nxt_state = bit_in ? ST_TAIL01 : ST_LOCKED;
            ST_LOCKED: nxt_state = ST_LOCKED;
            default:   nxt_state = ST_START;
        endcase
    end

endmodule

// File: rtl/sk_out_decode.sv
// Module: Moore output decode.
// Assumes: the state input comes straight from a register, so the flag is glitch-free.
module sk_out_decode
    import sk_pkg::*;
(
    input  sk_state_e cur_state,
    output logic      match_flag
);

    // Purpose: raise the flag only in the state that records a completed 0,1,0.
    always_comb begin
        match_flag = (cur_state == ST_HIT);
    end

endmodule

// File: rtl/sk_pattern_recognizer.sv
// Module: top of the serial 0,1,0 recognizer with a permanent 1,0,0 lockout.
// Assumes: x and rst_n are synchronous to clk; rst_n is active low and
// synchronous, and it overrides x.
module sk_pattern_recognizer
    import sk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic z
);

    sk_state_e state_q;
    sk_state_e state_d;

    sk_next_state u_next (
        .cur_state (state_q),
        .bit_in    (x),
        .nxt_state (state_d)
    );

    sk_out_decode u_dec (
        .cur_state  (state_q),
        .match_flag (z)
    );

    // Purpose: state register with synchronous reset taking priority over x.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_START && !z)); // R1

    AST_MATCH_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        z |-> (!$past(x,1) && $past(x,2) && !$past(x,3))); // R2

    AST_LOCK_ON_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n,1) && $past(rst_n,2) && $past(x,2) && !$past(x,1) && !x)
        |=> (state_q == ST_LOCKED)); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED && !z)); // R5

    AST_REUSE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (z && x) |=> (state_q == ST_TAIL01)); // R3

endmodule

// File: tb/sk_pattern_recognizer_bench.sv
module sk_pattern_recognizer_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic z;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int hist[$];
    bit killed = 1'b0;
    bit exp_z = 1'b0;

    always #5 clk = ~clk;

    sk_pattern_recognizer u_sk_pattern_recognizer (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: z=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit r_n, input bit b);
        if (!r_n) begin
            hist.delete();
            killed = 1'b0;
            exp_z = 1'b0;
        end else begin
            hist.push_back(int'(b));
            if (hist.size() > 3) void'(hist.pop_front());
            if (hist.size() == 3 && hist[0] == 1 && hist[1] == 0 && hist[2] == 0)
                killed = 1'b1;
            exp_z = !killed && hist.size() == 3 &&
                    hist[0] == 0 && hist[1] == 1 && hist[2] == 0;
        end
    endtask

    // one clock: drive at falling edge, sample z mid-high and at the next falling edge
    task automatic step(input bit r_n, input bit b, input string tag);
        logic mid;
        rst_n = r_n;
        x = b;
        @(posedge clk);
        model_edge(r_n, b);
        #2;
        mid = z;
        x = ~b;                     // R7 probe: mid-cycle toggle must not move z
        #1;
        check({tag, " R7"}, z, mid);
        @(negedge clk);
        check(tag, z, exp_z);
    endtask

    task automatic seq(input string bits, input string tag);
        for (int i = 0; i < bits.len(); i++)
            step(1'b1, bits[i] == "1", tag);
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        seq("010", "R2");
        step(1'b0, 1'b0, "R1");
        seq("01010", "R3");
        step(1'b0, 1'b0, "R1");
        seq("0001010", "R8");
        step(1'b0, 1'b0, "R1");
        seq("11010", "R8");
        step(1'b0, 1'b0, "R1");
        seq("0100", "R5");
        seq("010101001010", "R5");
        step(1'b0, 1'b1, "R6");     // reset with x=1 still lands in initial state
        seq("010", "R6");
        step(1'b0, 1'b0, "R1");
        seq("1100", "R4");
        seq("0101101010", "R4");
        step(1'b0, 1'b0, "R6");
        seq("1010", "R2");
        // pseudo-random stream against the model
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step((i % 37) != 0, lfsr[0], "R2");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule